// File: doc/BRIEF.md
# Hashed Page Table Group Matcher

This block turns a virtual page number, a page-size selector and a segment-size code into the 64-bit compare word that the first doubleword of a hashed page table entry must carry. In the same step it searches a group of eight first doublewords for an entry that carries that word. A hit needs three things: equal tag bits, the entry's valid flag set, and a hash-kind flag that equals the requested primary or secondary kind. When several slots hit, the lowest slot index is reported. From a physical address the block also builds the second doubleword, which carries the real page number and the page-size encoding.

Page sizes come from a small register table. Each row holds a page shift, a size encoding and a mask of tag bits to ignore. A one-cycle configuration write updates one row. The whole group is presented in parallel with the request. All results appear in registers one clock after the request and keep their values until the next request.

Top module: `hpte_group_matcher`

## Requirements
- R1: After reset, resValid, hit, hitSlot, segErr, cmpWord and rWord are all zero. Every page-size row reads shift 12, encoding 0 and mask 0.
- R2: A request sampled with reqValid high at a rising edge raises resValid for exactly the following cycle. Without a request, hit, hitSlot, segErr, cmpWord and rWord keep their values.
- R3: The compare word is built as follows. Bits 63:7 hold ((reqVpn >> 11) & ~mask) << 7, with the 2-bit segment code OR-ed into bits 63:62. Bit 2 is 1 exactly when the selected shift is not 12. Bits 6:3 and 1:0 are 0.
- R4: Slot s is groupWords[64*s+63 : 64*s]. A slot matches when it XOR-ed with the compare word has no set bit in 63:7, its bit 0 (valid) is 1, and its bit 1 (secondary) equals reqSecondary.
- R5: When several slots match, hitSlot is the lowest matching index. With no match, hit and hitSlot are 0.
- R6: A segment code of 2 or 3 forces hit=0 and hitSlot=0 and sets segErr=1. The compare word and second doubleword are still produced. Codes 0 (256 MB) and 1 (1 TB) clear segErr.
- R7: The second doubleword is formed from paddr. With shift 12 it is paddr & 0x0FFF_FFFF_FFFF_F000. With any other shift, the address bits below the shift are cleared and the encoding << 12 is OR-ed in.
- R8: cfgWe high at a rising edge writes cfgShift, cfgEnc and cfgMask into row cfgIdx. A request at the next edge already uses the new row.
- R9: Entry bits 6:2 (large, lock, bolted and the two spare bits) do not affect whether a slot matches. Tag bits cleared by the row's mask do not affect matching either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqVpn | input | 64 | Virtual page number (virtual address >> 12) |
| reqPsize | input | 2 | Page-size row index |
| reqSeg | input | 2 | Segment-size code |
| reqSecondary | input | 1 | 1 for secondary hash search |
| groupWords | input | 512 | Eight first doublewords, slot 0 in the low bits |
| paddr | input | 64 | Physical address for second-doubleword encoding |
| cfgWe | input | 1 | Page-size row write strobe |
| cfgIdx | input | 2 | Row to write |
| cfgShift | input | 6 | Page shift to write |
| cfgEnc | input | 4 | Size encoding to write |
| cfgMask | input | 64 | Tag ignore mask to write |
| resValid | output | 1 | Result strobe, one cycle after request |
| hit | output | 1 | A slot matched |
| hitSlot | output | 3 | Lowest matching slot |
| segErr | output | 1 | Reserved segment code seen |
| cmpWord | output | 64 | Encoded compare word |
| rWord | output | 64 | Encoded second doubleword |

## Verification
Every result register loads on the same edge that samples the request, so all outputs are due one edge after reqValid. A configuration write is due one edge after cfgWe, which means it applies to a request issued on the following edge. The bench drives inputs on the falling edge, waits one rising edge, and reads the outputs at the next falling edge. It then idles several cycles and confirms that the outputs hold. Expected words, hits and slots come from a separate model of the rules above, fed by the bench's own copy of the page-size table.

// File: rtl/hptm_pkg.sv
package hptm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load result registers
    logic tblWrite;  // write one page-size row
    logic segBad;    // reserved segment code on this request
  } hptm_strobe_t;

  localparam int AVPN_DROP  = 11;  // VPN bits dropped (23 VA bits total)
  localparam int TAG_LSB    = 7;   // lowest compared bit
  localparam int LARGE_BIT  = 2;
  localparam int VALID_BIT  = 0;
  localparam int SEC_BIT    = 1;
  localparam int BASE_SHIFT = 12;  // 4 KB page shift
  localparam logic [63:0] RPN_KEEP = 64'h0FFF_FFFF_FFFF_F000;
endpackage

// File: rtl/hptm_ctrl.sv
module hptm_ctrl
  import hptm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqSeg,
  input  logic         cfgWe,
  output hptm_strobe_t strobe,
  output logic         resValid
);
  always_comb begin
    strobe.capture  = reqValid;
    strobe.tblWrite = cfgWe;
    strobe.segBad   = reqValid & reqSeg[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= reqValid;
  end

  // R2: result strobe follows a request by one cycle
  a_r2_res_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  a_r2_no_spurious_res: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
endmodule

// File: rtl/hptm_datapath.sv
module hptm_datapath
  import hptm_pkg::*;
#(
  parameter int DW      = 64,
  parameter int SLOTS   = 8,
  parameter int PSIZES  = 4,
  parameter int SHIFT_W = 6,
  parameter int ENC_W   = 4,
  localparam int IDX_W  = $clog2(PSIZES),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hptm_strobe_t          strobe,
  input  logic [DW-1:0]         reqVpn,
  input  logic [IDX_W-1:0]      reqPsize,
  input  logic [1:0]            reqSeg,
  input  logic                  reqSecondary,
  input  logic [SLOTS*DW-1:0]   groupWords,
  input  logic [DW-1:0]         paddr,
  input  logic [IDX_W-1:0]      cfgIdx,
  input  logic [SHIFT_W-1:0]    cfgShift,
  input  logic [ENC_W-1:0]      cfgEnc,
  input  logic [DW-1:0]         cfgMask,
  output logic                  hit,
  output logic [SLOT_W-1:0]     hitSlot,
  output logic                  segErr,
  output logic [DW-1:0]         cmpWord,
  output logic [DW-1:0]         rWord
);
  localparam logic [DW-1:0] TAG_KEEP = ~DW'((1 << TAG_LSB) - 1);

  logic [SHIFT_W-1:0] shiftTab [PSIZES];
  logic [ENC_W-1:0]   encTab   [PSIZES];
  logic [DW-1:0]      maskTab  [PSIZES];

  always_ff @(posedge clk) begin
    for (int e = 0; e < PSIZES; e++) begin
      if (!rstN) begin
        shiftTab[e] <= SHIFT_W'(BASE_SHIFT);
        encTab[e]   <= '0;
        maskTab[e]  <= '0;
      end else if (strobe.tblWrite && cfgIdx == IDX_W'(e)) begin
        shiftTab[e] <= cfgShift;
        encTab[e]   <= cfgEnc;
        maskTab[e]  <= cfgMask;
      end
    end
  end

  // Compare-word and second-doubleword encoding
  logic [SHIFT_W-1:0] shiftSel;
  logic [DW-1:0]      avpn, cmpNext, rNext;
  logic               isLarge;

  always_comb begin
    shiftSel = shiftTab[reqPsize];
    isLarge  = (shiftSel != SHIFT_W'(BASE_SHIFT));
    avpn     = (reqVpn >> AVPN_DROP) & ~maskTab[reqPsize];
    cmpNext  = (avpn << TAG_LSB) | {reqSeg, {(DW-2){1'b0}}}
             | (DW'(isLarge) << LARGE_BIT);
    if (!isLarge) rNext = paddr & RPN_KEEP;
    else rNext = (paddr & ~((DW'(1) << shiftSel) - DW'(1)))
               | (DW'(encTab[reqPsize]) << BASE_SHIFT);
  end

  // Per-slot match
  logic [SLOTS-1:0] matchVec;
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DW-1:0] slotWord;
    assign slotWord    = groupWords[s*DW +: DW];
    assign matchVec[s] = (((slotWord ^ cmpNext) & TAG_KEEP) == '0)
                       && slotWord[VALID_BIT]
                       && (slotWord[SEC_BIT] == reqSecondary);
  end

  // Lowest index wins
  logic              anyMatch;
  logic [SLOT_W-1:0] firstSlot;
  always_comb begin
    anyMatch  = 1'b0;
    firstSlot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch  = 1'b1;
        firstSlot = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit     <= 1'b0;
      hitSlot <= '0;
      segErr  <= 1'b0;
      cmpWord <= '0;
      rWord   <= '0;
    end else if (strobe.capture) begin
      hit     <= anyMatch & ~strobe.segBad;
      hitSlot <= (anyMatch & ~strobe.segBad) ? firstSlot : '0;
      segErr  <= strobe.segBad;
      cmpWord <= cmpNext;
      rWord   <= rNext;
    end
  end

  // R3: low control bits of the compare word other than large stay clear
  a_r3_low_bits_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmpWord[TAG_LSB-1:LARGE_BIT+1] == '0 && cmpWord[SEC_BIT:VALID_BIT] == '0);
  // R6: reserved segment never reports a hit
  a_r6_err_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    segErr |-> !hit);
  // R8: a configuration write lands in the addressed row
  a_r8_cfg_written: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tblWrite |=> shiftTab[$past(cfgIdx)] == $past(cfgShift)
                        && maskTab[$past(cfgIdx)] == $past(cfgMask));
endmodule

// File: rtl/hpte_group_matcher.sv
module hpte_group_matcher
  import hptm_pkg::*;
#(
  parameter int DW      = 64,
  parameter int SLOTS   = 8,
  parameter int PSIZES  = 4,
  parameter int SHIFT_W = 6,
  parameter int ENC_W   = 4,
  localparam int IDX_W  = $clog2(PSIZES),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [DW-1:0]       reqVpn,
  input  logic [IDX_W-1:0]    reqPsize,
  input  logic [1:0]          reqSeg,
  input  logic                reqSecondary,
  input  logic [SLOTS*DW-1:0] groupWords,
  input  logic [DW-1:0]       paddr,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [SHIFT_W-1:0]  cfgShift,
  input  logic [ENC_W-1:0]    cfgEnc,
  input  logic [DW-1:0]       cfgMask,
  output logic                resValid,
  output logic                hit,
  output logic [SLOT_W-1:0]   hitSlot,
  output logic                segErr,
  output logic [DW-1:0]       cmpWord,
  output logic [DW-1:0]       rWord
);
  hptm_strobe_t strobe;

  hptm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSeg(reqSeg),
    .cfgWe(cfgWe), .strobe(strobe), .resValid(resValid)
  );

  hptm_datapath #(
    .DW(DW), .SLOTS(SLOTS), .PSIZES(PSIZES), .SHIFT_W(SHIFT_W), .ENC_W(ENC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqVpn(reqVpn), .reqPsize(reqPsize), .reqSeg(reqSeg),
    .reqSecondary(reqSecondary), .groupWords(groupWords), .paddr(paddr),
    .cfgIdx(cfgIdx), .cfgShift(cfgShift), .cfgEnc(cfgEnc), .cfgMask(cfgMask),
    .hit(hit), .hitSlot(hitSlot), .segErr(segErr),
    .cmpWord(cmpWord), .rWord(rWord)
  );
endmodule

// File: tb/hpte_group_matcher_bench.sv
module hpte_group_matcher_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic         reqValid = 0, reqSecondary = 0, cfgWe = 0;
  logic [63:0]  reqVpn = 0, paddr = 0, cfgMask = 0;
  logic [1:0]   reqPsize = 0, reqSeg = 0, cfgIdx = 0;
  logic [511:0] groupWords = 0;
  logic [5:0]   cfgShift = 0;
  logic [3:0]   cfgEnc = 0;
  logic         resValid, hit, segErr;
  logic [2:0]   hitSlot;
  logic [63:0]  cmpWord, rWord;

  hpte_group_matcher u_hpte_group_matcher (.*);

  int checks = 0, fails = 0;
  logic [63:0] grp [8];
  int          mShift [4];
  logic [3:0]  mEnc [4];
  logic [63:0] mMask [4];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] eCmp(logic [63:0] vpn, int idx, logic [1:0] seg);
    logic [63:0] w;
    w = ((vpn >> 11) & ~mMask[idx]) << 7;
    w = w | {seg, 62'd0};
    if (mShift[idx] != 12) w = w | 64'h4;
    return w;
  endfunction

  function automatic logic [63:0] eR(logic [63:0] pa, int idx);
    if (mShift[idx] == 12) return pa & 64'h0FFF_FFFF_FFFF_F000;
    return (pa & ~((64'd1 << mShift[idx]) - 1)) | (64'(mEnc[idx]) << 12);
  endfunction

  task automatic cfgWrite(int idx, int sh, logic [3:0] en, logic [63:0] mk);
    @(negedge clk);
    cfgWe = 1; cfgIdx = 2'(idx); cfgShift = 6'(sh); cfgEnc = en; cfgMask = mk;
    mShift[idx] = sh; mEnc[idx] = en; mMask[idx] = mk;
    @(negedge clk);
    cfgWe = 0;
  endtask

  // Issue a request; check every output against the model
  task automatic doReq(string req, logic [63:0] vpn, int idx, logic [1:0] seg,
                       logic sec, logic [63:0] pa);
    logic [63:0] c;
    logic        eHit;
    logic [2:0]  eSlot;
    c = eCmp(vpn, idx, seg);
    eHit = 0; eSlot = 0;
    if (!seg[1])
      for (int s = 7; s >= 0; s--)
        if ((((grp[s] ^ c) & ~64'h7F) == 0) && grp[s][0] && grp[s][1] == sec) begin
          eHit = 1; eSlot = 3'(s);
        end
    @(negedge clk);
    reqValid = 1; reqVpn = vpn; reqPsize = 2'(idx); reqSeg = seg;
    reqSecondary = sec; paddr = pa;
    for (int s = 0; s < 8; s++) groupWords[s*64 +: 64] = grp[s];
    @(negedge clk);
    reqValid = 0;
    chk({req, " resValid"}, 64'(resValid), 64'd1);
    chk({req, " hit"}, 64'(hit), 64'(eHit));
    chk({req, " hitSlot"}, 64'(hitSlot), 64'(eSlot));
    chk({req, " segErr"}, 64'(segErr), 64'(seg[1]));
    chk({req, " cmpWord"}, cmpWord, c);
    chk({req, " rWord"}, rWord, eR(pa, idx));
  endtask

  task automatic fillMiss();
    for (int s = 0; s < 8; s++) grp[s] = 64'hAAAA_0000_0000_0081 + 64'(s << 8);
  endtask

  task automatic t_reset();
    chk("R1 resValid", 64'(resValid), 0);
    chk("R1 hit", 64'(hit), 0);
    chk("R1 hitSlot", 64'(hitSlot), 0);
    chk("R1 segErr", 64'(segErr), 0);
    chk("R1 cmpWord", cmpWord, 0);
    chk("R1 rWord", rWord, 0);
    // default row 3: shift 12, enc 0, mask 0
    fillMiss();
    doReq("R1 default row", 64'h0000_0ABC_DEF1_2345, 3, 0, 0, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_primary();
    logic [63:0] v = 64'h0000_1234_5678_9ABC;
    fillMiss();
    grp[3] = eCmp(v, 0, 0) | 64'h1;
    doReq("R4 primary", v, 0, 0, 0, 64'h0000_0000_8765_4321);
    chk("R4 slot3", 64'(hitSlot), 3);
  endtask

  task automatic t_secondary();
    logic [63:0] v = 64'h0000_0F0F_1111_2222;
    fillMiss();
    grp[2] = eCmp(v, 0, 1) | 64'h1;
    grp[5] = eCmp(v, 0, 1) | 64'h3;
    doReq("R4 secondary", v, 0, 1, 1, 64'h0);
    chk("R4 secondary slot", 64'(hitSlot), 5);
    doReq("R4 primary kind", v, 0, 1, 0, 64'h0);
    chk("R4 primary slot", 64'(hitSlot), 2);
  endtask

  task automatic t_priority();
    logic [63:0] v = 64'h0000_0000_7777_0001;
    fillMiss();
    grp[0] = eCmp(v, 0, 0);          // valid clear
    grp[1] = eCmp(v, 0, 0) | 64'h1;
    grp[6] = eCmp(v, 0, 0) | 64'h1;
    doReq("R5 lowest", v, 0, 0, 0, 64'h0);
    chk("R5 lowest slot", 64'(hitSlot), 1);
    fillMiss();
    grp[4] = (eCmp(v, 0, 0) ^ 64'h80) | 64'h1;  // differs at bit 7
    doReq("R5 miss", v, 0, 0, 0, 64'h0);
    chk("R5 miss hit", 64'(hit), 0);
  endtask

  task automatic t_reserved();
    logic [63:0] v = 64'h0000_0000_3333_4444;
    fillMiss();
    grp[0] = eCmp(v, 0, 2) | 64'h1;
    grp[1] = eCmp(v, 0, 3) | 64'h1;
    doReq("R6 code2", v, 0, 2, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 code2 nohit", 64'(hit), 0);
    doReq("R6 code3", v, 0, 3, 0, 64'h0);
    chk("R6 code3 err", 64'(segErr), 1);
    grp[0] = eCmp(v, 0, 0) | 64'h1;
    doReq("R6 code0 clears", v, 0, 0, 0, 64'h0);
  endtask

  task automatic t_large();
    logic [63:0] v = 64'h0000_0000_00AB_CFFF;
    cfgWrite(1, 16, 4'h1, 64'h0);
    doReq("R8 immediate", v, 1, 0, 0, 64'h0000_0012_3456_7FFF);
    cfgWrite(3, 34, 4'h3, 64'h7FF);
    fillMiss();
    grp[7] = eCmp(v, 3, 1) | 64'h1;
    doReq("R3 masked", v, 3, 1, 0, 64'h0000_00F3_ABCD_1234);
    chk("R3 large bit", 64'(cmpWord[2]), 1);
    doReq("R9 masked tag bits", v ^ 64'h0000_0000_0000_F800, 3, 1, 0, 64'h0);
    chk("R9 masked hit", 64'(hit), 1);
    doReq("R7 shift12 row", v, 0, 0, 0, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_ignored();
    logic [63:0] v = 64'h0000_0000_5555_AAAA;
    fillMiss();
    grp[2] = eCmp(v, 0, 0) | 64'h7D;   // bits 6:2 set, secondary clear
    doReq("R9 ctrl bits", v, 0, 0, 0, 64'h0);
    chk("R9 slot2", 64'(hitSlot), 2);
  endtask

  task automatic t_hold();
    logic [63:0] c = cmpWord, r = rWord;
    logic        h = hit;
    logic [2:0]  sl = hitSlot;
    repeat (3) @(negedge clk);
    chk("R2 resValid low", 64'(resValid), 0);
    chk("R2 hit hold", 64'(hit), 64'(h));
    chk("R2 slot hold", 64'(hitSlot), 64'(sl));
    chk("R2 cmp hold", cmpWord, c);
    chk("R2 r hold", rWord, r);
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mShift[i] = 12; mEnc[i] = 0; mMask[i] = 0; end
    for (int s = 0; s < 8; s++) grp[s] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_primary();
    t_hold();
    t_secondary();
    t_priority();
    t_reserved();
    t_large();
    t_ignored();
    t_hold();
    finishRun();
  end
endmodule